// File: doc/BRIEF.md
# Scan-Line Sync and Control Sequencer

This block sets the nibble-rate timing for a bitmap display controller that serves several terminals over a shared link. It divides a bit-rate clock into two quadrature link clocks and a nibble clock. It then walks a host-programmed horizontal table, one entry per nibble. Each table entry carries four flags. One flag opens the control phase of a scan line. One ends the line. One drives horizontal sync. One marks the reference instant for vertical sync. The active address that steps the table is also the read address for the line buffers, which sit outside this block.

The block produces these outputs:
- a one-nibble line-switch pulse
- horizontal and vertical sync
- a send-control gate and a drop-clock flag, which switch the link from video to control nibbles and suppress the second link clock
- a blanking flag
- an even/odd line flag
- a latched per-line wakeup request for the host's task

There is no streaming data path, so every pin is a plain control or status signal. For diagnostics, the host can stop the oscillator divider and step it one bit-time at a time through control-register writes.

Top module: `scanline_seq`

## Requirements
- R1: The divider state (clk_a, raw second clock) runs 00 → 10 → 11 → 01 → 00, one step per bit-clock while the oscillator enable (control bit 0) is set. nclk is high only in state 00. Each nibble tick happens on the step that leaves state 00.
- R2: While the oscillator enable is clear, the divider moves only on control writes:
  - a write with bit 1 set clears the state to 00 without a tick, and it takes priority over bit 2;
  - a write with bit 2 set advances the state one step;
  - four advancing writes make one nibble.
- R3: The active address starts at 0 and increments by one (wrapping at the address width) on each nibble tick. A table write (ram_wdata bit 0 = set-control-phase, bit 1 = hsync, bit 2 = switch, bit 3 = vertical reference) goes to the entry at the current active address.
- R4: An entry's hsync and switch flags take effect only if the control phase is already set when that entry is read. Otherwise the registered hsync and line_switch outputs stay 0.
- R5: Reading an entry with the set-control-phase flag sets the control phase from that tick onward. `blank` shows the control phase.
- R6: Reading an effective switch entry does four things at that tick:
  - clears the control phase;
  - loads the active address with the start value times four;
  - toggles odd_line;
  - copies the next-VS (control bit 4) and odd-field (control bit 5) settings into a line shadow.
  line_switch is high for the following nibble.
- R7: send_ctl is high during any nibble in which hsync or vsync is high, and for the one nibble after both go low. drop_clk_b repeats send_ctl one nibble later.
- R8: vsync takes the shadowed next-VS value at the tick where hsync falls if the shadowed odd-field bit is 1, or where the vertical reference flag falls if it is 0.
- R9: wake_req is set at the tick where line_switch falls, but only if the wake enable (control bit 3) is set and task_run is low. It stays set until a wake_clr strobe.
- R10: While the force-load bit (start_wdata bit 6) is set, every nibble tick loads the active address with the start value (start_wdata bits 5:0) times four.
- R11: The second link clock output clk_b is forced to 0 whenever drop_clk_b is high, and otherwise follows the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control word: osc enable, step clear, step increment, wake enable, next VS, odd field |
| start_we | input | 1 | Start register write strobe |
| start_wdata | input | 7 | Start value [5:0] and force-load bit [6] |
| ram_we | input | 1 | Horizontal table write strobe (at the active address) |
| ram_wdata | input | 4 | Table entry flags |
| task_run | input | 1 | Host task is running; suppresses new wakeups |
| wake_clr | input | 1 | Clears the wakeup request |
| clk_a | output | 1 | First link clock |
| clk_b | output | 1 | Second link clock, gated by drop_clk_b |
| nclk | output | 1 | Nibble clock |
| act_addr | output | 8 | Active address (line buffer read address) |
| line_switch | output | 1 | End-of-line pulse, one nibble wide |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| send_ctl | output | 1 | Send control nibbles instead of video |
| drop_clk_b | output | 1 | Tells the terminal to read control nibbles |
| blank | output | 1 | Control phase; video forced to zero |
| odd_line | output | 1 | Even/odd line flag |
| wake_req | output | 1 | Latched wakeup request |

## Verification
The hardest states to reach from the ports sit at line boundaries. The vertical-sync change depends on settings copied into the shadow at the previous switch, and wakeup suppression depends on task_run being high exactly at the nibble where the switch pulse ends. The bench stops the oscillator and moves the design one nibble at a time with four stepping control writes. It loads the line table through that same stepping, then runs several consecutive lines, changing the control word and task_run between them. A final free-running stretch exercises clock gating while the table's control phase raises drop_clk_b.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

  typedef struct packed {
    logic ml;
    logic sw;
    logic hs;
    logic setc;
  } hent_t;

  typedef struct packed {
    logic odd_field;
    logic next_vs;
    logic wake_en;
    logic inc;
    logic clr;
    logic osc_en;
  } ctlw_t;

  function automatic logic [1:0] gray_next(input logic [1:0] g);
    case (g)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/nib_clockgen.sv
module nib_clockgen (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic step_we,
  input  logic step_clr,
  input  logic step_inc,
  output logic tick,
  output logic ph_a,
  output logic ph_b,
  output logic nclk
);
  import scanseq_pkg::*;

  logic [1:0] g;
  logic       adv;
  logic       clr_now;

  assign clr_now = !osc_en && step_we && step_clr;
  assign adv     = osc_en || (step_we && step_inc && !step_clr);
  assign tick    = adv && (g == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       g <= 2'b00;
    else if (clr_now) g <= 2'b00;
    else if (adv)     g <= gray_next(g);
  end

  assign ph_a = g[1];
  assign ph_b = g[0];
  assign nclk = (g == 2'b00);

  p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> $countones(g ^ $past(g)) == 1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr_now) |=> $stable(g));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> nclk);

endmodule

// File: rtl/hctl_core.sv
module hctl_core #(
  parameter int AW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   ram_we,
  input  scanseq_pkg::hent_t     ram_wdata,
  input  logic [AW-3:0]          start,
  input  logic                   force_ld,
  output logic [AW-1:0]          aar,
  output scanseq_pkg::hent_t     hn,
  output logic                   hs_q,
  output logic                   sw_q,
  output logic                   ml_q,
  output logic                   cphase,
  output logic                   odd_line
);
  import scanseq_pkg::*;

  localparam int DEPTH = 1 << AW;

  hent_t         mem [DEPTH];
  hent_t         entry;
  logic [AW-1:0] reload;

  assign reload = {start, 2'b00};
  assign entry  = mem[aar];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ram_we) begin
      mem[aar] <= ram_wdata;
    end
  end

  always_comb begin
    hn.setc = entry.setc;
    hn.ml   = entry.ml;
    hn.hs   = entry.hs && cphase;
    hn.sw   = entry.sw && cphase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aar      <= '0;
      hs_q     <= 1'b0;
      sw_q     <= 1'b0;
      ml_q     <= 1'b0;
      cphase   <= 1'b0;
      odd_line <= 1'b0;
    end else if (tick) begin
      aar      <= (force_ld || hn.sw) ? reload : aar + 1'b1;
      hs_q     <= hn.hs;
      sw_q     <= hn.sw;
      ml_q     <= hn.ml;
      cphase   <= hn.sw ? 1'b0 : (hn.setc ? 1'b1 : cphase);
      odd_line <= odd_line ^ hn.sw;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !force_ld && !hn.sw) |=> aar == AW'($past(aar) + 1'b1));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cphase) |=> (!hs_q && !sw_q));

  p_cph_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hn.setc && !hn.sw) |=> cphase);

  p_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hn.sw) |=> (aar == $past(reload) && !cphase && sw_q));

  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_ld) |=> aar == $past(reload));

endmodule

// File: rtl/sync_gen.sv
module sync_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hs_q,
  input  logic sw_q,
  input  logic ml_q,
  input  logic hn_hs,
  input  logic hn_sw,
  input  logic hn_ml,
  input  logic cfg_nvs,
  input  logic cfg_odd,
  input  logic wake_en,
  input  logic task_run,
  input  logic wake_clr,
  output logic vs,
  output logic sctl,
  output logic drop,
  output logic wake
);
  logic sh_nvs;
  logic sh_odd;
  logic vs_edge;
  logic vs_d;
  logic sw_fall;

  assign vs_edge = sh_odd ? (hs_q && !hn_hs) : (ml_q && !hn_ml);
  assign vs_d    = vs_edge ? sh_nvs : vs;
  assign sw_fall = sw_q && !hn_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs     <= 1'b0;
      sctl   <= 1'b0;
      drop   <= 1'b0;
      sh_nvs <= 1'b0;
      sh_odd <= 1'b0;
    end else if (tick) begin
      vs   <= vs_d;
      sctl <= hn_hs || vs_d || hs_q || vs;
      drop <= sctl;
      if (hn_sw) begin
        sh_nvs <= cfg_nvs;
        sh_odd <= cfg_odd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          wake <= 1'b0;
    else if (tick && sw_fall && wake_en && !task_run)    wake <= 1'b1;
    else if (wake_clr)                                   wake <= 1'b0;
  end

  p_sctl_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_q || vs) |-> sctl);

  p_drop_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> drop == $past(sctl));

  p_vs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !vs_edge) |=> $stable(vs));

  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> ($past(wake_en) && !$past(task_run)));

endmodule

// File: rtl/scanline_seq.sv
module scanline_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [5:0]    ctl_wdata,
  input  logic          start_we,
  input  logic [AW-2:0] start_wdata,
  input  logic          ram_we,
  input  logic [3:0]    ram_wdata,
  input  logic          task_run,
  input  logic          wake_clr,
  output logic          clk_a,
  output logic          clk_b,
  output logic          nclk,
  output logic [AW-1:0] act_addr,
  output logic          line_switch,
  output logic          hsync,
  output logic          vsync,
  output logic          send_ctl,
  output logic          drop_clk_b,
  output logic          blank,
  output logic          odd_line,
  output logic          wake_req
);
  import scanseq_pkg::*;

  localparam int SW = AW - 2;

  ctlw_t         cw;
  logic          osc_en_q, wake_en_q, nvs_q, oddf_q;
  logic [SW-1:0] start_q;
  logic          force_q;
  logic          tick, ph_b, ml_q;
  hent_t         hn;

  assign cw = ctlw_t'(ctl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
      nvs_q     <= 1'b0;
      oddf_q    <= 1'b0;
      start_q   <= '0;
      force_q   <= 1'b0;
    end else begin
      if (ctl_we) begin
        osc_en_q  <= cw.osc_en;
        wake_en_q <= cw.wake_en;
        nvs_q     <= cw.next_vs;
        oddf_q    <= cw.odd_field;
      end
      if (start_we) begin
        start_q <= start_wdata[SW-1:0];
        force_q <= start_wdata[SW];
      end
    end
  end

  nib_clockgen u_clk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en_q),
    .step_we(ctl_we), .step_clr(cw.clr), .step_inc(cw.inc),
    .tick(tick), .ph_a(clk_a), .ph_b(ph_b), .nclk(nclk)
  );

  hctl_core #(.AW(AW)) u_hctl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ram_we(ram_we), .ram_wdata(hent_t'(ram_wdata)),
    .start(start_q), .force_ld(force_q),
    .aar(act_addr), .hn(hn), .hs_q(hsync), .sw_q(line_switch),
    .ml_q(ml_q), .cphase(blank), .odd_line(odd_line)
  );

  sync_gen u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hs_q(hsync), .sw_q(line_switch), .ml_q(ml_q),
    .hn_hs(hn.hs), .hn_sw(hn.sw), .hn_ml(hn.ml),
    .cfg_nvs(nvs_q), .cfg_odd(oddf_q), .wake_en(wake_en_q),
    .task_run(task_run), .wake_clr(wake_clr),
    .vs(vsync), .sctl(send_ctl), .drop(drop_clk_b), .wake(wake_req)
  );

  assign clk_b = ph_b && !drop_clk_b;

  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drop_clk_b |-> !clk_b);

endmodule

// File: tb/tb_scanline_seq.sv
module tb_scanline_seq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we = 0, start_we = 0, ram_we = 0, task_run = 0, wake_clr = 0;
  logic [5:0] ctl_wdata = '0;
  logic [6:0] start_wdata = '0;
  logic [3:0] ram_wdata = '0;
  logic       clk_a, clk_b, nclk, line_switch, hsync, vsync, send_ctl;
  logic       drop_clk_b, blank, odd_line, wake_req;
  logic [7:0] act_addr;

  always #(CLK_P/2) clk = ~clk;

  scanline_seq dut (.*);

  int checks = 0, errors = 0;
  logic [3:0] mram [256];
  logic [7:0] m_aar;
  logic m_cph, m_hs, m_sw, m_ml, m_vs, m_sctl, m_drop, m_wake, m_odd;
  logic m_sh_nvs, m_sh_odd;
  logic m_osc, m_wen, m_nvs, m_oddf, m_force;
  logic [5:0] m_start;
  logic [3:0] seq_a = 4'b0110;  // index k -> bit k
  logic [3:0] seq_b = 4'b1100;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  task automatic model_tick();
    logic [3:0] e;
    logic nset, nhs, nsw, nml, vs_n, edge_v;
    e = mram[m_aar];
    nset = e[0]; nhs = e[1] & m_cph; nsw = e[2] & m_cph; nml = e[3];
    edge_v = m_sh_odd ? (m_hs & ~nhs) : (m_ml & ~nml);
    vs_n = edge_v ? m_sh_nvs : m_vs;
    m_drop = m_sctl;
    m_sctl = nhs | vs_n | m_hs | m_vs;
    if (m_sw & ~nsw & m_wen & ~task_run) m_wake = 1;
    if (nsw) begin m_sh_nvs = m_nvs; m_sh_odd = m_oddf; end
    m_aar = (m_force | nsw) ? {m_start, 2'b00} : m_aar + 8'd1;
    m_cph = nsw ? 1'b0 : (nset ? 1'b1 : m_cph);
    m_odd = m_odd ^ nsw;
    m_vs = vs_n; m_hs = nhs; m_sw = nsw; m_ml = nml;
  endtask

  task automatic ctl_write(input logic clr, input logic inc);
    ctl_wdata = {m_oddf, m_nvs, m_wen, inc, clr, m_osc};
    ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic start_write(input logic frc, input logic [5:0] s);
    start_wdata = {frc, s}; start_we = 1;
    @(negedge clk);
    start_we = 0; m_force = frc; m_start = s;
  endtask

  task automatic ram_write(input logic [3:0] d);
    ram_wdata = d; ram_we = 1;
    @(negedge clk);
    ram_we = 0; mram[m_aar] = d;
  endtask

  task automatic compare_all();
    chk(act_addr, m_aar, "R3 active address");
    chk(hsync, m_hs, "R4 hsync");
    chk(line_switch, m_sw, "R6 line_switch");
    chk(blank, m_cph, "R5 blank/control phase");
    chk(odd_line, m_odd, "R6 odd_line");
    chk(vsync, m_vs, "R8 vsync");
    chk(send_ctl, m_sctl, "R7 send_ctl");
    chk(drop_clk_b, m_drop, "R7 drop_clk_b");
    chk(wake_req, m_wake, "R9 wake_req");
  endtask

  task automatic step();
    for (int k = 1; k <= 4; k++) begin
      if (k == 1) model_tick();
      ctl_write(1'b0, 1'b1);
      chk(clk_a, seq_a[k % 4], "R1 clk_a in step");
      chk(nclk, (k % 4) == 0, "R1 nclk in step");
      chk(clk_b, seq_b[k % 4] & ~m_drop, "R2 clk_b in step");
    end
    compare_all();
  endtask

  function automatic logic [3:0] tbl(input int i);
    if (i == 2 || i == 3) return 4'b1000;
    if (i == 5 || (i >= 11 && i <= 13)) return 4'b0010;
    if (i == 9 || i == 15) return 4'b0100;
    if (i == 10) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic run_line(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mram[i] = '0;
    m_aar = 0; m_cph = 0; m_hs = 0; m_sw = 0; m_ml = 0; m_vs = 0; m_sctl = 0;
    m_drop = 0; m_wake = 0; m_odd = 0; m_sh_nvs = 0; m_sh_odd = 0;
    m_osc = 0; m_wen = 0; m_nvs = 0; m_oddf = 0; m_force = 0; m_start = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R1, R3, R9)
    chk(act_addr, 0, "R3 reset address");
    chk(nclk, 1, "R1 reset nclk");
    chk(clk_a, 0, "R1 reset clk_a");
    compare_all();

    // R2: clear and increment single-step
    model_tick();
    ctl_write(1'b0, 1'b1);
    ctl_write(1'b0, 1'b1);
    chk(clk_a, 1, "R2 state 11 clk_a");
    chk(clk_b, 1, "R2 state 11 clk_b");
    ctl_write(1'b1, 1'b0);
    chk(nclk, 1, "R2 clear returns to 00");
    chk(act_addr, m_aar, "R2 clear makes no tick");
    ctl_write(1'b1, 1'b1);
    chk(nclk, 1, "R2 clear beats increment");
    chk(act_addr, m_aar, "R2 clear+inc makes no tick");
    compare_all();

    // R10: force load
    start_write(1'b1, 6'd5);
    step();
    chk(act_addr, 20, "R10 force load start*4");
    step();
    chk(act_addr, 20, "R10 force load holds");
    start_write(1'b1, 6'd0);
    step();
    chk(act_addr, 0, "R10 force load to zero");
    start_write(1'b0, 6'd0);

    // load line table through stepping (R3, R4, R5, R6)
    for (int i = 0; i < 16; i++) begin
      ram_write(tbl(i));
      step();
    end
    chk(act_addr, 0, "R6 switch reloads start*4");

    // line A: wake enabled, next VS = 1 on ML fall
    m_wen = 1; m_nvs = 1; m_oddf = 0;
    ctl_write(1'b0, 1'b0);
    step();
    chk(wake_req, 1, "R9 wake set at switch fall");
    @(negedge clk) wake_clr = 1;
    @(negedge clk) wake_clr = 0;
    m_wake = 0;
    chk(wake_req, 0, "R9 wake cleared by strobe");
    run_line(15);

    // line B: task running, next VS = 0 on HS fall
    task_run = 1;
    m_nvs = 0; m_oddf = 1;
    ctl_write(1'b0, 1'b0);
    run_line(16);
    chk(vsync, 1, "R8 vsync rose at ML fall");

    // line C: wake blocked by running task
    step();
    chk(wake_req, 0, "R9 task_run blocks wake");
    task_run = 0;
    run_line(15);
    chk(vsync, 0, "R8 vsync fell at HS fall");

    // line D: wake enable cleared
    m_wen = 0;
    ctl_write(1'b0, 1'b0);
    run_line(16);
    step();
    chk(wake_req, 0, "R9 enable bit blocks wake");

    // free run (R1, R11)
    m_osc = 1;
    ctl_write(1'b0, 1'b0);
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      chk(clk_a, seq_a[k % 4], "R1 free-run clk_a");
      chk(nclk, (k % 4) == 0, "R1 free-run nclk");
      chk(clk_b, seq_b[k % 4] & ~drop_clk_b, "R11 clk_b gating");
    end
    summary();
  end
endmodule